// File: doc/BRIEF.md
# Effective Address and Extra-Cycle Unit

This block is the address-generation stage of a processor core that has an 8-bit data bus and a 24-bit address space. The address space is made of 256 banks of 64 KiB. The decoder supplies an addressing-mode class and the operand bytes. The block combines them with the direct-page base, the data bank, the index register and the program counter. From these it produces three results in the same cycle:

- the 24-bit effective address,
- the address of the next instruction,
- a single flag that asks the bus sequencer for one inserted cycle.

A registered running total adds each instruction's base cycle count and its extra cycle when the core signals that the instruction is complete.

Whether the extra cycle is inserted depends on several things: the low byte of the direct-page base, whether the access writes, the width of the index registers, and whether the index addition crosses a 256-byte page. Long-addressed indexed modes never pay the extra cycle. Branches pay it only in emulation mode and only when the target lies in another page. The program counter always stays inside its own bank. A 16-bit operand may sit at an odd address with no cost, because the bus fetches one byte at a time.

Top module: `agu_top`

## Requirements
- R1: In direct-page modes (mode 4 = direct, mode 5 = direct indexed), the effective address is in bank zero. Its low 16 bits equal base + operand[7:0], plus the index in mode 5, wrapped to 16 bits. The extra flag is 1 exactly when dp_base[7:0] is nonzero.
- R2: In absolute indexed mode (mode 1), a write or read-modify-write (is_write = 1) always raises the extra flag, whether or not a page is crossed.
- R3: In mode 1, a 16-bit index (index_is8 = 0) always raises the extra flag. When index_is8 = 1, only index_val[7:0] takes part in the address.
- R4: In mode 1, a read with an 8-bit index raises the extra flag exactly when operand[7:0] + index crosses a 256-byte boundary.
- R5: In long indexed mode (mode 3), the address is operand[23:0] + index wrapped to 24 bits, and the extra flag is never raised.
- R6: In mode 1, the address is {data_bank, operand[15:0]} + index computed over 24 bits, so a carry out of the low 16 bits increments the bank byte.
- R7: In branch mode (mode 6), the extra flag is raised only when all three hold: the branch is taken, emu_mode = 1, and the target's page differs from the page of pc + instr_len. The target is pc + instr_len + sign-extended operand[7:0].
- R8: next_pc keeps pc[23:0]'s bank byte for every mode, and its low 16 bits wrap for both sequential steps and branch targets.
- R9: In absolute mode (mode 0), the address is {data_bank, operand[15:0]} with no penalty, including odd (unaligned) operands. In long mode (mode 2) the address is operand[23:0] with no penalty. In mode 7 the address is zero with no penalty.
- R10: When several penalty conditions hold for one access, exactly one extra cycle is added to the total.
- R11: cycle_total is cleared by synchronous reset. On a cycle with instr_done = 1 it grows by base_cycles + extra_cycle. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Addressing-mode class (0 abs, 1 abs indexed, 2 long, 3 long indexed, 4 direct, 5 direct indexed, 6 branch, 7 none) |
| dp_base | input | 16 | Direct-page base register |
| data_bank | input | 8 | Data bank byte |
| index_val | input | 16 | Index register value |
| index_is8 | input | 1 | 1 = 8-bit index registers |
| emu_mode | input | 1 | 1 = emulation mode |
| is_write | input | 1 | 1 = write or read-modify-write access |
| br_taken | input | 1 | Branch condition is true |
| operand | input | 24 | Operand bytes, low byte first |
| pc | input | 24 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes |
| base_cycles | input | 4 | Cycle count of the instruction without penalty |
| instr_done | input | 1 | Instruction-complete strobe |
| eff_addr | output | 24 | Effective address; for branches, the next PC |
| next_pc | output | 24 | Address of the next instruction |
| extra_cycle | output | 1 | One inserted bus cycle is needed |
| cycle_total | output | 32 | Running cycle total |

## Verification
The bench goes after several edges of the design, and each has a distinct failure:

- **Page crossing for indexed reads.** An index that just reaches the next page is tested against one that stays one byte short. A design that tests the 16-bit carry instead of the low-byte carry would miss penalties.
- **Bank carry.** An indexed access near the top of a bank is tested. A design that drops the carry into the bank byte would return an address in the wrong bank.
- **PC wrap.** Branch targets and sequential steps that cross $FFFF are tested. A design with a full 24-bit add there would move the program counter into the next bank.
- **Stacked penalties.** Accesses where write, 16-bit index and page cross all hold at once are tested. A design that sums the penalties would overcount the total.
- **Excluded cases.** Long indexed modes and branches in native mode are checked to confirm they leave the extra flag low.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int BANK_W = 8;
  localparam int OFS_W  = 16;
  localparam int ADDR_W = BANK_W + OFS_W;

  typedef enum logic [2:0] {
    AM_ABS    = 3'd0,
    AM_ABS_X  = 3'd1,
    AM_LONG   = 3'd2,
    AM_LONG_X = 3'd3,
    AM_DP     = 3'd4,
    AM_DP_X   = 3'd5,
    AM_REL    = 3'd6,
    AM_NONE   = 3'd7
  } amode_e;

  // index as seen by the adder: high byte forced to zero in 8-bit mode
  function automatic logic [OFS_W-1:0] index_view(input logic [OFS_W-1:0] raw, input logic is8);
    return is8 ? {{(OFS_W-8){1'b0}}, raw[7:0]} : raw;
  endfunction

  // carry out of the low byte of base + index
  function automatic logic low_byte_carry(input logic [7:0] base_lo, input logic [7:0] idx_lo);
    logic [8:0] s;
    s = {1'b0, base_lo} + {1'b0, idx_lo};
    return s[8];
  endfunction

  // add within a bank: low 16 bits wrap, bank kept
  function automatic logic [ADDR_W-1:0] bank_local_add(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] d);
    logic [OFS_W-1:0] lo;
    lo = a[OFS_W-1:0] + d;
    return {a[ADDR_W-1:OFS_W], lo};
  endfunction
endpackage

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
(
  input  amode_e              mode,
  input  logic [OFS_W-1:0]    dp_base,
  input  logic [BANK_W-1:0]   data_bank,
  input  logic [OFS_W-1:0]    idx,
  input  logic [ADDR_W-1:0]   operand,
  output logic [ADDR_W-1:0]   ea,
  output logic                abs_page_cross,
  output logic                dp_unaligned
);
  logic [ADDR_W-1:0] idx_wide;
  logic [ADDR_W-1:0] op16_wide;
  logic [OFS_W-1:0]  op8_wide;
  logic [OFS_W-1:0]  dp_sum;
  logic [OFS_W-1:0]  dp_x_sum;
  logic [ADDR_W-1:0] abs_x_sum;
  logic [ADDR_W-1:0] long_x_sum;

  assign idx_wide   = {{BANK_W{1'b0}}, idx};
  assign op16_wide  = {data_bank, operand[OFS_W-1:0]};
  assign op8_wide   = {{(OFS_W-8){1'b0}}, operand[7:0]};
  assign dp_sum     = dp_base + op8_wide;
  assign dp_x_sum   = dp_sum + idx;
  assign abs_x_sum  = op16_wide + idx_wide;
  assign long_x_sum = operand + idx_wide;

  assign abs_page_cross = low_byte_carry(operand[7:0], idx[7:0]);
  assign dp_unaligned   = |dp_base[7:0];

  always_comb begin
    case (mode)
      AM_ABS:    ea = op16_wide;
      AM_ABS_X:  ea = abs_x_sum;
      AM_LONG:   ea = operand;
      AM_LONG_X: ea = long_x_sum;
      AM_DP:     ea = {{BANK_W{1'b0}}, dp_sum};
      AM_DP_X:   ea = {{BANK_W{1'b0}}, dp_x_sum};
      default:   ea = '0;
    endcase
  end
endmodule

// File: rtl/agu_pc_next.sv
module agu_pc_next
  import agu_pkg::*;
(
  input  amode_e             mode,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [1:0]         instr_len,
  input  logic               taken,
  input  logic [7:0]         rel_off,
  output logic [ADDR_W-1:0]  npc,
  output logic               br_page_cross
);
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;
  logic              do_branch;

  assign seq_pc    = bank_local_add(pc, {{(OFS_W-2){1'b0}}, instr_len});
  assign tgt_pc    = bank_local_add(seq_pc, {{(OFS_W-8){rel_off[7]}}, rel_off});
  assign do_branch = (mode == AM_REL) && taken;
  assign npc       = do_branch ? tgt_pc : seq_pc;
  assign br_page_cross = do_branch && (seq_pc[OFS_W-1:8] != tgt_pc[OFS_W-1:8]);
endmodule

// File: rtl/agu_penalty_eval.sv
module agu_penalty_eval
  import agu_pkg::*;
(
  input  amode_e mode,
  input  logic   dp_unaligned,
  input  logic   abs_page_cross,
  input  logic   is_write,
  input  logic   index_is8,
  input  logic   emu_mode,
  input  logic   br_page_cross,
  output logic   pen_dp,
  output logic   pen_index,
  output logic   pen_branch,
  output logic   extra
);
  logic is_dp_mode;
  assign is_dp_mode = (mode == AM_DP) || (mode == AM_DP_X);
  assign pen_dp     = is_dp_mode && dp_unaligned;
  assign pen_index  = (mode == AM_ABS_X) && (is_write || !index_is8 || abs_page_cross);
  assign pen_branch = (mode == AM_REL) && emu_mode && br_page_cross;
  // at most one inserted cycle, whatever the number of causes
  assign extra      = pen_dp | pen_index | pen_branch;
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [15:0]       dp_base,
  input  logic [7:0]        data_bank,
  input  logic [15:0]       index_val,
  input  logic              index_is8,
  input  logic              emu_mode,
  input  logic              is_write,
  input  logic              br_taken,
  input  logic [23:0]       operand,
  input  logic [23:0]       pc,
  input  logic [1:0]        instr_len,
  input  logic [BASE_W-1:0] base_cycles,
  input  logic              instr_done,
  output logic [23:0]       eff_addr,
  output logic [23:0]       next_pc,
  output logic              extra_cycle,
  output logic [CNT_W-1:0]  cycle_total
);
  amode_e            am;
  logic [OFS_W-1:0]  idx_eff;
  logic [ADDR_W-1:0] ea_data;
  logic              abs_page_cross;
  logic              dp_unaligned;
  logic              br_page_cross;
  logic              pen_dp, pen_index, pen_branch;

  assign am      = amode_e'(mode);
  assign idx_eff = index_view(index_val, index_is8);

  agu_ea_calc u_ea (
    .mode(am), .dp_base(dp_base), .data_bank(data_bank), .idx(idx_eff),
    .operand(operand), .ea(ea_data), .abs_page_cross(abs_page_cross),
    .dp_unaligned(dp_unaligned)
  );

  agu_pc_next u_pc (
    .mode(am), .pc(pc), .instr_len(instr_len), .taken(br_taken),
    .rel_off(operand[7:0]), .npc(next_pc), .br_page_cross(br_page_cross)
  );

  agu_penalty_eval u_pen (
    .mode(am), .dp_unaligned(dp_unaligned), .abs_page_cross(abs_page_cross),
    .is_write(is_write), .index_is8(index_is8), .emu_mode(emu_mode),
    .br_page_cross(br_page_cross), .pen_dp(pen_dp), .pen_index(pen_index),
    .pen_branch(pen_branch), .extra(extra_cycle)
  );

  assign eff_addr = (am == AM_REL) ? next_pc : ea_data;

  always_ff @(posedge clk) begin
    if (rst)             cycle_total <= '0;
    else if (instr_done) cycle_total <= cycle_total + CNT_W'(base_cycles) + CNT_W'(extra_cycle);
  end

  assert_dp_aligned_free_R1: assert property (@(posedge clk) disable iff (rst)
    ((am == AM_DP || am == AM_DP_X) && dp_base[7:0] == 8'h00) |-> !extra_cycle);
  assert_dp_bank_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (am == AM_DP || am == AM_DP_X) |-> (eff_addr[23:16] == 8'h00));
  assert_write_index_pen_R2: assert property (@(posedge clk) disable iff (rst)
    (am == AM_ABS_X && is_write) |-> extra_cycle);
  assert_wide_index_pen_R3: assert property (@(posedge clk) disable iff (rst)
    (am == AM_ABS_X && !index_is8) |-> extra_cycle);
  assert_long_no_pen_R5: assert property (@(posedge clk) disable iff (rst)
    (am == AM_LONG_X) |-> !extra_cycle);
  assert_native_branch_free_R7: assert property (@(posedge clk) disable iff (rst)
    (am == AM_REL && !emu_mode) |-> !extra_cycle);
  assert_pc_bank_kept_R8: assert property (@(posedge clk) disable iff (rst)
    next_pc[23:16] == pc[23:16]);
  assert_plain_abs_free_R9: assert property (@(posedge clk) disable iff (rst)
    (am == AM_ABS || am == AM_LONG || am == AM_NONE) |-> !extra_cycle);
  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> cycle_total == $past(cycle_total) + CNT_W'($past(base_cycles)) + CNT_W'($past(extra_cycle)));
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !instr_done |=> $stable(cycle_total));
endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic [15:0] dp_base;
  logic [7:0]  data_bank;
  logic [15:0] index_val;
  logic        index_is8, emu_mode, is_write, br_taken, instr_done;
  logic [23:0] operand, pc;
  logic [1:0]  instr_len;
  logic [3:0]  base_cycles;
  logic [23:0] eff_addr, next_pc;
  logic        extra_cycle;
  logic [31:0] cycle_total;

  int     n_checks = 0;
  int     n_fail   = 0;
  bit     finished = 0;
  longint model_total = 0;

  always #5 clk = ~clk;

  agu_top u_dut (
    .clk(clk), .rst(rst), .mode(mode), .dp_base(dp_base), .data_bank(data_bank),
    .index_val(index_val), .index_is8(index_is8), .emu_mode(emu_mode),
    .is_write(is_write), .br_taken(br_taken), .operand(operand), .pc(pc),
    .instr_len(instr_len), .base_cycles(base_cycles), .instr_done(instr_done),
    .eff_addr(eff_addr), .next_pc(next_pc), .extra_cycle(extra_cycle),
    .cycle_total(cycle_total)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference, integer arithmetic
  task automatic model(output longint ea, output longint npc, output longint xc);
    longint ix, seqv, off, tgt, lo;
    ix   = index_is8 ? (index_val & 255) : index_val;
    seqv = ((pc & 'hFFFF) + instr_len) % 65536;
    npc  = (pc / 65536) * 65536 + seqv;
    xc   = 0;
    case (mode)
      3'd0: ea = data_bank * 65536 + (operand % 65536);
      3'd1: begin
        ea = (data_bank * 65536 + (operand % 65536) + ix) % (1 << 24);
        if (is_write || !index_is8 || ((operand % 256) + (ix % 256)) > 255) xc = 1;
      end
      3'd2: ea = operand;
      3'd3: ea = (operand + ix) % (1 << 24);
      3'd4, 3'd5: begin
        ea = (dp_base + (operand % 256) + ((mode == 3'd5) ? ix : 0)) % 65536;
        if ((dp_base % 256) != 0) xc = 1;
      end
      3'd6: begin
        off = operand % 256;
        if (off > 127) off = off - 256;
        tgt = (seqv + off + 65536) % 65536;
        lo  = br_taken ? tgt : seqv;
        npc = (pc / 65536) * 65536 + lo;
        ea  = npc;
        if (br_taken && emu_mode && (seqv / 256) != (tgt / 256)) xc = 1;
      end
      default: ea = 0;
    endcase
  endtask

  task automatic step(input string tag, input int m, input int dp, input int bk, input int ix,
                      input bit i8, input bit em, input bit wr, input bit tk, input int op,
                      input int p, input int ln, input int bc, input bit dn);
    longint e_ea, e_npc, e_x;
    mode = 3'(m); dp_base = 16'(dp); data_bank = 8'(bk); index_val = 16'(ix);
    index_is8 = i8; emu_mode = em; is_write = wr; br_taken = tk;
    operand = 24'(op); pc = 24'(p); instr_len = 2'(ln); base_cycles = 4'(bc); instr_done = dn;
    #1;
    model(e_ea, e_npc, e_x);
    check(tag, "eff_addr", eff_addr, e_ea);
    check(tag, "next_pc", next_pc, e_npc);
    check(tag, "extra_cycle", extra_cycle, e_x);
    @(posedge clk);
    if (dn) model_total = (model_total + bc + e_x) % (64'd1 << 32);
    @(negedge clk);
    check(tag, "cycle_total", cycle_total, model_total);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    step("R11_reset", 7, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    model_total = 0;
    check("R11_reset", "cycle_total", cycle_total, 0);
    rst = 1'b0;

    step("R1",  4, 'h1200, 'h55, 0, 1, 0, 0, 0, 'h34, 'h010000, 2, 3, 1);
    step("R1",  4, 'h1201, 'h55, 0, 1, 0, 0, 0, 'h34, 'h010000, 2, 3, 1);
    step("R1",  5, 'hFFF0, 'h55, 'h0005, 1, 0, 0, 0, 'h20, 'h010000, 2, 4, 1);
    step("R4",  1, 0, 'h22, 'h0005, 1, 0, 0, 0, 'h10F0, 'h020000, 3, 4, 1);
    step("R4",  1, 0, 'h22, 'h0010, 1, 0, 0, 0, 'h10F0, 'h020000, 3, 4, 1);
    step("R4",  1, 0, 'h22, 'h000F, 1, 0, 0, 0, 'h10F0, 'h020000, 3, 4, 1);
    step("R2",  1, 0, 'h22, 'h0005, 1, 0, 1, 0, 'h10F0, 'h020000, 3, 5, 1);
    step("R3",  1, 0, 'h22, 'h0105, 0, 0, 0, 0, 'h1000, 'h020000, 3, 4, 1);
    step("R3",  1, 0, 'h22, 'hAB05, 1, 0, 0, 0, 'h1000, 'h020000, 3, 4, 1);
    step("R6",  1, 0, 'h7E, 'h0020, 1, 0, 0, 0, 'hFFF0, 'h020000, 3, 4, 1);
    step("R10", 1, 0, 'h7E, 'h01F0, 0, 0, 1, 0, 'h12F0, 'h020000, 3, 6, 1);
    step("R5",  3, 0, 'h7E, 'hFFF0, 0, 0, 1, 0, 'h7EFFF0, 'h020000, 0, 5, 1);
    step("R7",  6, 0, 0, 0, 1, 1, 0, 1, 'h20, 'h0380F0, 2, 2, 1);
    step("R7",  6, 0, 0, 0, 1, 0, 0, 1, 'h20, 'h0380F0, 2, 2, 1);
    step("R7",  6, 0, 0, 0, 1, 1, 0, 0, 'h20, 'h0380F0, 2, 2, 1);
    step("R7",  6, 0, 0, 0, 1, 1, 0, 1, 'hF0, 'h038005, 2, 2, 1);
    step("R8",  6, 0, 0, 0, 1, 0, 0, 1, 'h7F, 'h05FFF0, 2, 2, 1);
    step("R8",  7, 0, 0, 0, 1, 0, 0, 0, 0, 'h12FFFF, 3, 2, 1);
    step("R9",  0, 'h0001, 'h33, 'hFFFF, 0, 1, 1, 1, 'h1235, 'h120000, 3, 4, 1);
    step("R9",  2, 'h0001, 'h33, 'hFFFF, 0, 1, 1, 1, 'hC01235, 'h120000, 0, 5, 1);
    step("R11", 1, 0, 'h22, 'h0105, 0, 0, 1, 0, 'h1000, 'h020000, 3, 7, 0);
    step("R11", 4, 'h00FF, 0, 0, 1, 0, 0, 0, 'h01, 'h020000, 2, 9, 0);

    for (int k = 0; k < 600; k++) begin
      int m;
      string t;
      m = int'($urandom_range(0, 7));
      case (m)
        0, 2, 7: t = "R9";
        1:       t = "R2/R3/R4/R6";
        3:       t = "R5";
        4, 5:    t = "R1";
        default: t = "R7/R8";
      endcase
      step(t, m, int'($urandom_range(0, 3)) == 0 ? int'($urandom & 'hFF00) : int'($urandom & 'hFFFF),
           int'($urandom & 'hFF), int'($urandom & 'hFFFF), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), int'($urandom & 'hFFFFFF), int'($urandom & 'hFFFFFF),
           int'($urandom_range(0, 3)), int'($urandom_range(0, 15)), 1'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule